// File: doc/BRIEF.md
# Daisy Chain Target Slot Node

This block is one stop on a ring of fixed-width message slots that carries commands, write data and responses between a central controller and many register blocks. Every clock the node takes in one slot and sends out one slot a cycle later. It decodes the slot header. A command or write-data message addressed to this node is stored in a local queue, and its slot is released. Every other slot travels on unchanged.

When a queue has no room, the node cannot store the message. It sends the message onward with a retry mark, and the controller resends it. To keep the register side in the order the messages were issued, the node records the first message it turned away. It then turns away every later message for itself until that one returns and is taken. Responses from the register side wait in a response queue and go into the first slot that is free. A free slot is either one that arrives empty or one the node has just released. A pending interrupt takes such a slot before any queued response.

Top module: `dcn_target_node`

## Requirements
- R1: While reset is held, and after it is released, `slot_o` has its valid field cleared. The command, write-data and response queues are empty, and no interrupt is pending.
- R2: A slot is live when its top 2 bits equal 2'b01. A live slot that is not a command or write data addressed to this node appears on `slot_o` bit for bit, exactly one clock later. Below the valid field, the layout from the MSB down is: kind (2 bits: 00 command, 01 write data, 10 response), response code (2 bits: 00 OK, 01 ERROR, 10 RETRY, 11 INTERRUPT), write flag (1), same-address flag (1), target ID, transfer ID, remaining count, then the payload in the LSBs.
- R3: A live command with target ID equal to `MY_ID` is stored whole in the command queue when that queue is not full and no retry record blocks it. One clock later its slot leaves with the valid field set to 2'b00, unless a response fills that slot.
- R4: A live write-data message for this node is stored in the write-data queue and its slot is released, under the same conditions as R3.
- R5: A message for this node whose queue is full is not stored. It leaves one clock later with its response code set to RETRY (2'b10), and all other fields unchanged.
- R6: After the first retry, the node records that message's kind and transfer ID. Every later message for this node is retried, even when its queue has room, until the recorded message arrives and is stored. Storing it clears the record.
- R7: When the recorded message is write data, the match also requires equal remaining count. A write-data beat of the same transfer with a different count is still retried.
- R8: A queued response is placed only into a free slot. It goes out as a live response with kind 10, this node's target ID, and the code OK, or ERROR when `rsp_err_i` was set. It carries the pushed transfer ID, count and data, and the write flag from `rsp_write_i`.
- R9: A pending interrupt takes the next free slot ahead of all queued responses. It goes out with code INTERRUPT, transfer ID 0, count 0, and the vector as payload. `irq_pend_o` then clears.
- R10: Each queue returns entries in arrival order, with `*_full_o` set at `*_DEPTH` entries and `*_empty_o` set at zero entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_i | input | SLOT_W (35) | Slot from the previous node |
| slot_o | output | SLOT_W (35) | Slot to the next node |
| cmd_pop_i | input | 1 | Remove head of command queue |
| cmd_head_o | output | SLOT_W (35) | Head command slot |
| cmd_empty_o | output | 1 | Command queue empty |
| cmd_full_o | output | 1 | Command queue full |
| wd_pop_i | input | 1 | Remove head of write-data queue |
| wd_head_o | output | SLOT_W (35) | Head write-data slot |
| wd_empty_o | output | 1 | Write-data queue empty |
| wd_full_o | output | 1 | Write-data queue full |
| rsp_push_i | input | 1 | Enqueue a response |
| rsp_err_i | input | 1 | Response reports an error |
| rsp_write_i | input | 1 | Response belongs to a write |
| rsp_xid_i | input | XID_W (4) | Response transfer ID |
| rsp_size_i | input | SIZE_W (4) | Response remaining count |
| rsp_data_i | input | PAY_W (16) | Response data |
| rsp_full_o | output | 1 | Response queue full |
| irq_i | input | 1 | Interrupt request, latched when none is pending |
| irq_vec_i | input | PAY_W (16) | Interrupt vector |
| irq_pend_o | output | 1 | Interrupt waiting for a free slot |

## Verification
Some rules are checked by the assertions on every cycle. A foreign live slot must come out unchanged one cycle later. An addressed message that meets a full queue, or one that meets an active retry record without matching it, must leave marked RETRY. A pending interrupt must win an incoming empty slot, and a queued response must fill an empty slot when no interrupt waits. Other behaviour shows only in the bench's scenarios. These are the exact contents stored in each queue and their order, and the point at which a returning recorded message releases the lock. They also cover the count-sensitive match for write data, and the full format of inserted responses, including a response that lands in a slot the node has just released.

// File: rtl/dcn_pkg.sv
package dcn_pkg;
  parameter int TID_W  = 3;
  parameter int XID_W  = 4;
  parameter int SIZE_W = 4;
  parameter int PAY_W  = 16;
  localparam int HDR_W  = 8;
  localparam int SLOT_W = HDR_W + TID_W + XID_W + SIZE_W + PAY_W;
  localparam int RSP_W  = 3 + XID_W + SIZE_W + PAY_W;

  localparam logic [1:0] V_FREE = 2'b00;
  localparam logic [1:0] V_LIVE = 2'b01;
  localparam logic [1:0] K_CMD  = 2'b00;
  localparam logic [1:0] K_WDAT = 2'b01;
  localparam logic [1:0] K_RSP  = 2'b10;
  localparam logic [1:0] C_OK   = 2'b00;
  localparam logic [1:0] C_ERR  = 2'b01;
  localparam logic [1:0] C_RTRY = 2'b10;
  localparam logic [1:0] C_INTR = 2'b11;

  typedef struct packed {
    logic [1:0]        vld;
    logic [1:0]        kind;
    logic [1:0]        code;
    logic              wr;
    logic              same;
    logic [TID_W-1:0]  tgt;
    logic [XID_W-1:0]  xid;
    logic [SIZE_W-1:0] size;
    logic [PAY_W-1:0]  pay;
  } slot_t;

  function automatic logic slot_live(slot_t s);
    return s.vld == V_LIVE;
  endfunction

  function automatic logic slot_is_req(slot_t s);
    return slot_live(s) && (s.kind == K_CMD || s.kind == K_WDAT);
  endfunction

  function automatic slot_t build_rsp(logic [TID_W-1:0] tgt, logic [1:0] code, logic wr,
                                      logic [XID_W-1:0] xid, logic [SIZE_W-1:0] sz,
                                      logic [PAY_W-1:0] pay);
    slot_t s;
    s.vld  = V_LIVE;
    s.kind = K_RSP;
    s.code = code;
    s.wr   = wr;
    s.same = 1'b0;
    s.tgt  = tgt;
    s.xid  = xid;
    s.size = sz;
    s.pay  = pay;
    return s;
  endfunction
endpackage

// File: rtl/dcn_fifo.sv
module dcn_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_p, rd_p;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] adv(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_p];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_p] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wr_p <= adv(wr_p);
      if (do_pop)  rd_p <= adv(rd_p);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/dcn_retry_guard.sv
module dcn_retry_guard
  import dcn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retry,
  input  logic              accept,
  input  logic [1:0]        kind,
  input  logic [XID_W-1:0]  xid,
  input  logic [SIZE_W-1:0] size,
  output logic              lock_q,
  output logic              rec_match
);
  logic [1:0]        rec_kind;
  logic [XID_W-1:0]  rec_xid;
  logic [SIZE_W-1:0] rec_size;

  assign rec_match = lock_q && kind == rec_kind && xid == rec_xid &&
                     (kind != K_WDAT || size == rec_size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      rec_kind <= '0;
      rec_xid  <= '0;
      rec_size <= '0;
    end else if (retry && !lock_q) begin
      lock_q   <= 1'b1;
      rec_kind <= kind;
      rec_xid  <= xid;
      rec_size <= size;
    end else if (accept && lock_q) begin
      lock_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dcn_resp_inject.sv
module dcn_resp_inject
  import dcn_pkg::*;
#(
  parameter int MY_ID = 2
) (
  input  logic              free,
  input  logic              irq_pend,
  input  logic [PAY_W-1:0]  irq_vec,
  input  logic              rsp_empty,
  input  logic [RSP_W-1:0]  rsp_head,
  output logic              take_irq,
  output logic              take_rsp,
  output logic [SLOT_W-1:0] ins_slot
);
  logic [1:0]        h_code;
  logic              h_wr;
  logic [XID_W-1:0]  h_xid;
  logic [SIZE_W-1:0] h_size;
  logic [PAY_W-1:0]  h_pay;

  assign {h_code, h_wr, h_xid, h_size, h_pay} = rsp_head;
  assign take_irq = free && irq_pend;
  assign take_rsp = free && !irq_pend && !rsp_empty;

  always_comb begin
    if (irq_pend)
      ins_slot = build_rsp(TID_W'(MY_ID), C_INTR, 1'b0, '0, '0, irq_vec);
    else
      ins_slot = build_rsp(TID_W'(MY_ID), h_code, h_wr, h_xid, h_size, h_pay);
  end
endmodule

// File: rtl/dcn_target_node.sv
module dcn_target_node
  import dcn_pkg::*;
#(
  parameter int MY_ID     = 2,
  parameter int CMD_DEPTH = 4,
  parameter int WD_DEPTH  = 4,
  parameter int RSP_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [SLOT_W-1:0] slot_o,
  input  logic              cmd_pop_i,
  output logic [SLOT_W-1:0] cmd_head_o,
  output logic              cmd_empty_o,
  output logic              cmd_full_o,
  input  logic              wd_pop_i,
  output logic [SLOT_W-1:0] wd_head_o,
  output logic              wd_empty_o,
  output logic              wd_full_o,
  input  logic              rsp_push_i,
  input  logic              rsp_err_i,
  input  logic              rsp_write_i,
  input  logic [XID_W-1:0]  rsp_xid_i,
  input  logic [SIZE_W-1:0] rsp_size_i,
  input  logic [PAY_W-1:0]  rsp_data_i,
  output logic              rsp_full_o,
  input  logic              irq_i,
  input  logic [PAY_W-1:0]  irq_vec_i,
  output logic              irq_pend_o
);
  slot_t             in_s, nxt_s, out_q, ins_s;
  logic              hit, is_cmd, room, accept, retry, free_w;
  logic              lock_q, rec_match;
  logic              cmd_push, wd_push;
  logic              take_irq, take_rsp, rsp_empty_w;
  logic [RSP_W-1:0]  rsp_head_w, rsp_din;
  logic [SLOT_W-1:0] ins_raw;
  logic [PAY_W-1:0]  irq_vec_q;

  assign in_s   = slot_t'(slot_i);
  assign hit    = slot_is_req(in_s) && in_s.tgt == TID_W'(MY_ID);
  assign is_cmd = in_s.kind == K_CMD;
  assign room   = is_cmd ? !cmd_full_o : !wd_full_o;
  assign accept = hit && room && (!lock_q || rec_match);
  assign retry  = hit && !accept;
  assign free_w = !slot_live(in_s) || accept;

  assign cmd_push = accept && is_cmd;
  assign wd_push  = accept && !is_cmd;

  dcn_retry_guard u_guard (
    .clk(clk), .rst_n(rst_n), .retry(retry), .accept(accept),
    .kind(in_s.kind), .xid(in_s.xid), .size(in_s.size),
    .lock_q(lock_q), .rec_match(rec_match)
  );

  dcn_fifo #(.W(SLOT_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(slot_i), .pop(cmd_pop_i),
    .dout(cmd_head_o), .empty(cmd_empty_o), .full(cmd_full_o)
  );

  dcn_fifo #(.W(SLOT_W), .DEPTH(WD_DEPTH)) u_wd_q (
    .clk(clk), .rst_n(rst_n), .push(wd_push), .din(slot_i), .pop(wd_pop_i),
    .dout(wd_head_o), .empty(wd_empty_o), .full(wd_full_o)
  );

  assign rsp_din = {(rsp_err_i ? C_ERR : C_OK), rsp_write_i, rsp_xid_i, rsp_size_i, rsp_data_i};

  dcn_fifo #(.W(RSP_W), .DEPTH(RSP_DEPTH)) u_rsp_q (
    .clk(clk), .rst_n(rst_n), .push(rsp_push_i), .din(rsp_din), .pop(take_rsp),
    .dout(rsp_head_w), .empty(rsp_empty_w), .full(rsp_full_o)
  );

  dcn_resp_inject #(.MY_ID(MY_ID)) u_inject (
    .free(free_w), .irq_pend(irq_pend_o), .irq_vec(irq_vec_q),
    .rsp_empty(rsp_empty_w), .rsp_head(rsp_head_w),
    .take_irq(take_irq), .take_rsp(take_rsp), .ins_slot(ins_raw)
  );
  assign ins_s = slot_t'(ins_raw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pend_o <= 1'b0;
      irq_vec_q  <= '0;
    end else if (take_irq) begin
      irq_pend_o <= 1'b0;
    end else if (irq_i && !irq_pend_o) begin
      irq_pend_o <= 1'b1;
      irq_vec_q  <= irq_vec_i;
    end
  end

  always_comb begin
    nxt_s = in_s;
    if (retry)                      nxt_s.code = C_RTRY;
    else if (take_irq || take_rsp)  nxt_s = ins_s;
    else if (accept)                nxt_s.vld = V_FREE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= nxt_s;
  end

  assign slot_o = out_q;
endmodule

// File: rtl/dcn_target_node_chk.sv
module dcn_target_node_chk
  import dcn_pkg::*;
#(
  parameter int MY_ID = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SLOT_W-1:0] slot_i,
  input logic [SLOT_W-1:0] slot_o,
  input logic              cmd_full_o,
  input logic              irq_pend_o,
  input logic              rsp_empty,
  input logic              lock_q,
  input logic              rec_match
);
  logic [1:0] i_vld, i_kind, o_vld, o_kind, o_code;
  logic [TID_W-1:0] i_tgt;
  logic in_live, in_mine;

  assign i_vld   = slot_i[SLOT_W-1 -: 2];
  assign i_kind  = slot_i[SLOT_W-3 -: 2];
  assign i_tgt   = slot_i[SLOT_W-HDR_W-1 -: TID_W];
  assign o_vld   = slot_o[SLOT_W-1 -: 2];
  assign o_kind  = slot_o[SLOT_W-3 -: 2];
  assign o_code  = slot_o[SLOT_W-5 -: 2];
  assign in_live = i_vld == 2'b01;
  assign in_mine = in_live && i_kind != 2'b10 && i_kind != 2'b11 && i_tgt == TID_W'(MY_ID);

  always @(posedge clk) begin
    if (!rst_n) p_reset_free_r1: assert (o_vld != 2'b01);
  end

  p_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_live && !in_mine |=> slot_o == $past(slot_i));

  p_full_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_mine && i_kind == 2'b00 && cmd_full_o |=> o_vld == 2'b01 && o_code == 2'b10);

  p_order_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && in_mine && !rec_match |=> o_vld == 2'b01 && o_code == 2'b10);

  p_irq_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend_o && !in_live |=> o_vld == 2'b01 && o_kind == 2'b10 && o_code == 2'b11);

  p_rsp_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_empty && !irq_pend_o && !in_live |=> o_vld == 2'b01 && o_kind == 2'b10 && o_code != 2'b11);
endmodule

bind dcn_target_node dcn_target_node_chk #(.MY_ID(MY_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_i(slot_i), .slot_o(slot_o),
  .cmd_full_o(cmd_full_o), .irq_pend_o(irq_pend_o), .rsp_empty(rsp_empty_w),
  .lock_q(lock_q), .rec_match(rec_match)
);

// File: tb/dcn_target_node_tb_top.sv
module dcn_target_node_tb_top;
  import dcn_pkg::*;

  localparam int ME = 2;
  localparam logic [1:0] L = 2'b01, F = 2'b00;
  localparam logic [1:0] KC = 2'b00, KW = 2'b01, KR = 2'b10;
  localparam logic [1:0] OK = 2'b00, ER = 2'b01, RT = 2'b10, IN = 2'b11;

  function automatic logic [SLOT_W-1:0] mk(input logic [1:0] v, input logic [1:0] k,
      input logic [1:0] c, input logic w, input logic s, input int t, input int x,
      input int z, input int p);
    return {v, k, c, w, s, t[TID_W-1:0], x[XID_W-1:0], z[SIZE_W-1:0], p[PAY_W-1:0]};
  endfunction

  function automatic logic [2*SLOT_W+3:0] row(input int rq, input logic [SLOT_W-1:0] a,
                                               input logic [SLOT_W-1:0] b);
    return {rq[3:0], a, b};
  endfunction

  localparam logic [2*SLOT_W+3:0] TBL [6] = '{
    row(2, mk(L,KC,OK,0,0,5,1,0,16'h0101), mk(L,KC,OK,0,0,5,1,0,16'h0101)),  // R2 foreign cmd
    row(2, mk(L,KR,OK,0,0,1,2,0,16'h0202), mk(L,KR,OK,0,0,1,2,0,16'h0202)),  // R2 response
    row(2, '0, '0),                                                           // R2 free slot
    row(3, mk(L,KC,OK,1,1,ME,3,2,16'h3333), mk(F,KC,OK,1,1,ME,3,2,16'h3333)), // R3 captured
    row(4, mk(L,KW,OK,1,0,ME,4,1,16'h4444), mk(F,KW,OK,1,0,ME,4,1,16'h4444)), // R4 captured
    row(2, mk(L,KW,OK,1,0,6,4,1,16'h5555), mk(L,KW,OK,1,0,6,4,1,16'h5555))    // R2 foreign data
  };

  logic clk = 0, rst_n = 0;
  logic [SLOT_W-1:0] slot_i = '0, slot_o, cmd_head_o, wd_head_o;
  logic cmd_pop_i = 0, wd_pop_i = 0, rsp_push_i = 0, rsp_err_i = 0, rsp_write_i = 0, irq_i = 0;
  logic [XID_W-1:0] rsp_xid_i = '0;
  logic [SIZE_W-1:0] rsp_size_i = '0;
  logic [PAY_W-1:0] rsp_data_i = '0, irq_vec_i = '0;
  logic cmd_empty_o, cmd_full_o, wd_empty_o, wd_full_o, rsp_full_o, irq_pend_o;
  int n_chk = 0, n_err = 0, cyc = 0;

  always #5 clk = ~clk;

  dcn_target_node #(.MY_ID(ME)) dut_i (.*);

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step(input logic [SLOT_W-1:0] s);
    slot_i = s;
    @(negedge clk);
    slot_i = '0;
  endtask

  task automatic push_rsp(input logic e, input logic w, input int x, input int z, input int d);
    rsp_push_i = 1; rsp_err_i = e; rsp_write_i = w;
    rsp_xid_i = x[XID_W-1:0]; rsp_size_i = z[SIZE_W-1:0]; rsp_data_i = d[PAY_W-1:0];
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while and after reset
    check("R1 slot valid", 64'(slot_o[SLOT_W-1 -: 2]), 64'(F));
    rst_n = 1;
    @(negedge clk);
    check("R1 empties", {cmd_empty_o, wd_empty_o, rsp_full_o, irq_pend_o}, 4'b1100);
    check("R1 slot out", 64'(slot_o), 64'(0));

    foreach (TBL[i]) begin
      step(TBL[i][2*SLOT_W-1 -: SLOT_W]);
      check($sformatf("R%0d table row %0d", TBL[i][2*SLOT_W+3 -: 4], i),
            64'(slot_o), 64'(TBL[i][SLOT_W-1:0]));
    end
    check("R3 cmd head", 64'(cmd_head_o), 64'(TBL[3][2*SLOT_W-1 -: SLOT_W]));
    check("R4 wd head", 64'(wd_head_o), 64'(TBL[4][2*SLOT_W-1 -: SLOT_W]));
    cmd_pop_i = 1; wd_pop_i = 1; step('0); cmd_pop_i = 0; wd_pop_i = 0;
    check("R10 drained", {cmd_empty_o, wd_empty_o}, 2'b11);

    // R5 / R6: full queue, then ordered retries
    for (int x = 1; x <= 4; x++) step(mk(L,KC,OK,0,0,ME,x,0,x));
    check("R10 cmd full", 64'(cmd_full_o), 64'(1));
    step(mk(L,KC,OK,0,0,ME,5,0,5));
    check("R5 retry on full", 64'(slot_o), 64'(mk(L,KC,RT,0,0,ME,5,0,5)));
    step(mk(L,KW,OK,1,0,ME,6,0,6));
    check("R6 locked wdata", 64'(slot_o), 64'(mk(L,KW,RT,1,0,ME,6,0,6)));
    cmd_pop_i = 1; step('0); cmd_pop_i = 0;
    step(mk(L,KC,OK,0,0,ME,7,0,7));
    check("R6 room but locked", 64'(slot_o), 64'(mk(L,KC,RT,0,0,ME,7,0,7)));
    step(mk(L,KC,RT,0,0,ME,5,0,5));
    check("R6 recorded accepted", 64'(slot_o), 64'(mk(F,KC,RT,0,0,ME,5,0,5)));
    step(mk(L,KW,RT,1,0,ME,6,0,6));
    check("R6 lock released", 64'(slot_o), 64'(mk(F,KW,RT,1,0,ME,6,0,6)));
    for (int x = 2; x <= 5; x++) begin
      check("R10 cmd order", 64'(cmd_head_o), 64'(mk(L,KC,(x == 5) ? RT : OK,0,0,ME,x,0,x)));
      cmd_pop_i = 1; step('0); cmd_pop_i = 0;
    end
    wd_pop_i = 1; step('0); wd_pop_i = 0;
    check("R10 empty again", {cmd_empty_o, wd_empty_o}, 2'b11);

    // R7: write-data match includes remaining count
    for (int z = 3; z >= 0; z--) step(mk(L,KW,OK,1,0,ME,8,z,z));
    check("R10 wd full", 64'(wd_full_o), 64'(1));
    step(mk(L,KW,OK,1,0,ME,9,2,16'h92));
    check("R5 wd retry", 64'(slot_o), 64'(mk(L,KW,RT,1,0,ME,9,2,16'h92)));
    wd_pop_i = 1; step('0); step('0); wd_pop_i = 0;
    step(mk(L,KW,OK,1,0,ME,9,1,16'h91));
    check("R7 other beat retried", 64'(slot_o), 64'(mk(L,KW,RT,1,0,ME,9,1,16'h91)));
    step(mk(L,KW,RT,1,0,ME,9,2,16'h92));
    check("R7 recorded beat taken", 64'(slot_o[SLOT_W-1 -: 2]), 64'(F));
    step(mk(L,KW,RT,1,0,ME,9,1,16'h91));
    check("R7 next beat taken", 64'(slot_o[SLOT_W-1 -: 2]), 64'(F));
    wd_pop_i = 1; step('0); step('0); wd_pop_i = 0;
    check("R7 order head", 64'(wd_head_o), 64'(mk(L,KW,RT,1,0,ME,9,2,16'h92)));
    wd_pop_i = 1; step('0); step('0); wd_pop_i = 0;

    // R8: responses only in free slots
    push_rsp(0, 0, 3, 1, 16'hBEEF);
    step(mk(L,KC,OK,0,0,5,1,0,1));
    rsp_push_i = 0;
    check("R8 busy slot untouched", 64'(slot_o), 64'(mk(L,KC,OK,0,0,5,1,0,1)));
    step('0);
    check("R8 inserted", 64'(slot_o), 64'(mk(L,KR,OK,0,0,ME,3,1,16'hBEEF)));
    push_rsp(1, 1, 4, 0, 16'h1234);
    step(mk(L,KR,OK,0,0,6,1,0,7));
    rsp_push_i = 0;
    step(mk(L,KC,OK,0,0,ME,10,0,10));
    check("R8 freed slot reused", 64'(slot_o), 64'(mk(L,KR,ER,1,0,ME,4,0,16'h1234)));
    cmd_pop_i = 1; step(mk(L,KR,OK,0,0,6,1,0,7)); cmd_pop_i = 0;

    // R9: interrupt overtakes queued responses
    push_rsp(0, 0, 5, 0, 16'h0055);
    step(mk(L,KR,OK,0,0,6,1,0,7));
    push_rsp(0, 1, 6, 0, 16'h0066);
    irq_i = 1; irq_vec_i = 16'hA5A5;
    step(mk(L,KR,OK,0,0,6,1,0,7));
    rsp_push_i = 0; irq_i = 0;
    check("R9 pending", 64'(irq_pend_o), 64'(1));
    step('0);
    check("R9 irq first", 64'(slot_o), 64'(mk(L,KR,IN,0,0,ME,0,0,16'hA5A5)));
    check("R9 pending cleared", 64'(irq_pend_o), 64'(0));
    step('0);
    check("R8 queue order 1", 64'(slot_o), 64'(mk(L,KR,OK,0,0,ME,5,0,16'h0055)));
    step('0);
    check("R8 queue order 2", 64'(slot_o), 64'(mk(L,KR,OK,1,0,ME,6,0,16'h0066)));
    step('0);
    check("R8 nothing left", 64'(slot_o), 64'(0));

    finish_run();
  end
endmodule